// File: doc/BRIEF.md
# Flash Controller Lock and Abort Logic

This block is the protection and sequencing core of a small flash memory controller. It holds two software-visible registers. The control register carries a lock bit, a sticky access-violation flag, a ready indication and a self-clearing emergency-exit bit. The mode register carries the enables for word program, segment erase, mass erase and segment-write mode. A CPU write strobe aimed at the flash array starts the operation selected by the mode register, but only when the array is unlocked and no operation is running. A down-counter stands in for the real cell timing, and the block signals the start and end of each operation to the engine that drives the array.

A locked or overlapping array write is refused. It raises the violation flag, and the hardware also forces the lock on. Setting the lock while an operation runs lets that operation run to its end. In segment-write mode the lock takes effect once the current word is finished. Writing the emergency-exit bit kills the running operation in the next cycle and clears the whole mode register.

Top module: `flash_guard`

## Requirements
- R1: After reset, locked is 1, violation is 0, busy is 0, the mode register reads 0 and the ready bit reads 1.
- R2: reg_sel=1 selects the control register: bit 2 is the violation flag, bit 3 is ready, bit 4 is the lock and bit 5 is emergency exit. reg_sel=0 selects the mode register: bit 0 enables program, bit 1 segment erase, bit 2 mass erase and bit 3 segment-write mode. An array write made while unlocked and idle starts one operation. The priority is mass erase, then segment erase, then program (segment-write or program enable). With no enable set, the write starts nothing.
- R3: busy is high for exactly PROG_CYC, SEG_CYC or MASS_CYC cycles, starting in the cycle after the accepted strobe. op_start pulses for one cycle in the first busy cycle, with op_kind set to 0 for program, 1 for segment erase and 2 for mass erase. op_done pulses for one cycle in the first cycle after busy falls.
- R4: An array write while locked starts nothing and sets the violation flag.
- R5: Whenever the violation flag is set, locked is forced to 1. A control write that clears the lock in the same cycle as a new violation leaves the lock at 1.
- R6: The violation flag holds until a control write with bit 2 at 0. A control write with bit 2 at 1 neither sets nor clears it.
- R7: Setting the lock while an operation runs does not shorten it: busy stays high for the full duration and op_done still pulses.
- R8: In segment-write mode each accepted strobe programs one word, and ready stays 0 between words. Once the lock is set, the segment-write enable clears and ready returns to 1 after the current word ends.
- R9: A control write with bit 5 at 1 makes busy low in the next cycle, gives no op_done, clears every mode bit, and bit 5 always reads 0.
- R10: An array write while busy starts no new operation, leaves the running one unchanged and sets the violation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the mode register, 1 selects the control register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the register chosen by reg_sel |
| arr_wr | input | 1 | CPU write strobe to the flash array |
| op_start | output | 1 | One-cycle pulse when an operation starts |
| op_kind | output | 2 | Kind of the current operation |
| op_done | output | 1 | One-cycle pulse when an operation completes normally |
| busy | output | 1 | An operation is in progress |
| violation | output | 1 | Sticky access-violation flag |
| locked | output | 1 | Current lock state |

## Verification
The hardest situation to reach is the lock arriving in the middle of a segment-write session, between the strobe of one word and the end of its timing. The bench opens the session, lets the first word finish, and checks that ready stays low while idle. It then issues a second word and writes the lock two cycles into that word's count. After that it confirms the full duration, the op_done pulse, the cleared segment-write enable and the return of ready one cycle later. A second hard case is a lock release that lands in the same cycle as a violating strobe; the bench drives both inputs in one cycle.

// File: rtl/fg_pkg.sv
// Package fg_pkg: shared constants and types for the flash guard block.
// Assumes an 8-bit register port; bit positions are fixed by the register layout.
package fg_pkg;
    localparam int REG_W = 8;

    // Control register bit positions
    localparam int CTL_VIOL = 2;
    localparam int CTL_RDY  = 3;
    localparam int CTL_LOCK = 4;
    localparam int CTL_EMEX = 5;

    // Mode register bit positions
    localparam int MD_PROG  = 0;
    localparam int MD_SEGER = 1;
    localparam int MD_MASS  = 2;
    localparam int MD_SEGW  = 3;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SEGER = 2'd1,
        OP_MASS  = 2'd2,
        OP_NONE  = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic segw;
        logic mass;
        logic seger;
        logic prog;
    } mode_t;
endpackage

// File: rtl/fg_ctrl_regs.sv
// Module fg_ctrl_regs: holds the lock bit, the sticky violation flag and the
// mode register, decodes emergency exit and builds the read data.
// Assumes viol_set and segw_end come from the sequencer in the same cycle.
module fg_ctrl_regs
    import fg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             viol_set,
    input  logic             segw_end,
    input  logic             rdy,
    output logic             lock,
    output logic             viol,
    output mode_t            mode,
    output logic             emex_req,
    output logic [REG_W-1:0] reg_rdata
);
    logic ctl_wr;
    logic mode_wr;
    logic wdata_unused;

    assign ctl_wr       = reg_wr && reg_sel;
    assign mode_wr      = reg_wr && !reg_sel;
    assign emex_req     = ctl_wr && reg_wdata[CTL_EMEX];
    assign wdata_unused = ^{reg_wdata[7:6], reg_wdata[CTL_RDY], reg_wdata[1:0]};

    // Lock: hardware set on violation wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        lock <= 1'b1;
        else if (viol_set) lock <= 1'b1;
        else if (ctl_wr)   lock <= reg_wdata[CTL_LOCK];
    end

    // Violation flag: set by hardware, cleared only by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                               viol <= 1'b0;
        else if (viol_set)                        viol <= 1'b1;
        else if (ctl_wr && !reg_wdata[CTL_VIOL])  viol <= 1'b0;
    end

    // Mode register: software write, cleared by emergency exit, segw bit by mode end.
    always_ff @(posedge clk) begin
        if (!rst_n || emex_req) begin
            mode <= '0;
        end else if (mode_wr) begin
            mode.prog  <= reg_wdata[MD_PROG];
            mode.seger <= reg_wdata[MD_SEGER];
            mode.mass  <= reg_wdata[MD_MASS];
            mode.segw  <= reg_wdata[MD_SEGW];
        end else if (segw_end) begin
            mode.segw  <= 1'b0;
        end
    end

    // Read mux; emergency exit always reads back as 0.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[CTL_VIOL] = viol;
            reg_rdata[CTL_RDY]  = rdy;
            reg_rdata[CTL_LOCK] = lock;
        end else begin
            reg_rdata[MD_PROG]  = mode.prog;
            reg_rdata[MD_SEGER] = mode.seger;
            reg_rdata[MD_MASS]  = mode.mass;
            reg_rdata[MD_SEGW]  = mode.segw;
        end
    end
endmodule

// File: rtl/fg_op_seq.sv
// Module fg_op_seq: accepts or refuses array write strobes, picks the
// operation kind, times it with a down-counter and tracks segment-write mode.
// Assumes lock and mode are registered values; abort is a one-cycle request.
module fg_op_seq
    import fg_pkg::*;
#(
    parameter int PROG_CYC = 8,
    parameter int SEG_CYC  = 32,
    parameter int MASS_CYC = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     arr_wr,
    input  logic     lock,
    input  mode_t    mode,
    input  logic     abort,
    output logic     busy,
    output logic     op_start,
    output op_kind_e op_kind,
    output logic     op_done,
    output logic     segw_mode,
    output logic     segw_end,
    output logic     viol_set
);
    localparam int MAX_A = (PROG_CYC > SEG_CYC) ? PROG_CYC : SEG_CYC;
    localparam int MAXC  = (MAX_A > MASS_CYC) ? MAX_A : MASS_CYC;
    localparam int CW    = $clog2(MAXC) + 1;

    logic [CW-1:0] cnt;
    op_kind_e      kind_sel;
    logic          accept;
    logic          start;
    logic          enter_segw;
    logic          last;

    // Kind selection with fixed priority; a segment-write session always programs.
    always_comb begin
        if (segw_mode)       kind_sel = OP_PROG;
        else if (mode.mass)  kind_sel = OP_MASS;
        else if (mode.seger) kind_sel = OP_SEGER;
        else if (mode.segw || mode.prog) kind_sel = OP_PROG;
        else                 kind_sel = OP_NONE;
    end

    // Duration of each kind, minus one, as counter load value.
    function automatic logic [CW-1:0] load_of(op_kind_e k);
        case (k)
            OP_MASS:  load_of = CW'(MASS_CYC - 1);
            OP_SEGER: load_of = CW'(SEG_CYC - 1);
            default:  load_of = CW'(PROG_CYC - 1);
        endcase
    endfunction

    assign accept     = arr_wr && !lock && !busy;
    assign start      = accept && (kind_sel != OP_NONE) && !abort;
    assign viol_set   = arr_wr && (lock || busy);
    assign enter_segw = start && !segw_mode && (kind_sel == OP_PROG) && mode.segw;
    assign last       = busy && (cnt == '0);
    assign segw_end   = segw_mode && !busy && !abort && (lock || !mode.segw);

    // Counter and busy: load on start, count down, stop at zero or on abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= load_of(kind_sel);
        end else if (last) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt  <= cnt - 1'b1;
        end
    end

    // Handshake pulses and latched kind for the operation engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start <= 1'b0;
            op_done  <= 1'b0;
            op_kind  <= OP_NONE;
        end else begin
            op_start <= start;
            op_done  <= last && !abort;
            if (start) op_kind <= kind_sel;
        end
    end

    // Segment-write session: entered by its first word, left on lock, disable or abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort)  segw_mode <= 1'b0;
        else if (enter_segw)  segw_mode <= 1'b1;
        else if (segw_end)    segw_mode <= 1'b0;
    end
endmodule

// File: rtl/flash_guard.sv
// Module flash_guard: top of the flash lock and abort logic. Joins the
// register file and the operation sequencer.
// Assumes a single clock domain and synchronous inputs.
module flash_guard
    import fg_pkg::*;
#(
    parameter int PROG_CYC = 8,
    parameter int SEG_CYC  = 32,
    parameter int MASS_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       arr_wr,
    output logic       op_start,
    output logic [1:0] op_kind,
    output logic       op_done,
    output logic       busy,
    output logic       violation,
    output logic       locked
);
    logic     lock;
    logic     viol;
    mode_t    mode;
    logic     emex_req;
    logic     viol_set;
    logic     segw_end;
    logic     segw_mode;
    logic     rdy;
    op_kind_e kind;

    // Ready when nothing runs and no segment-write session is open.
    assign rdy       = !busy && !segw_mode;
    assign op_kind   = kind;
    assign violation = viol;
    assign locked    = lock;

    fg_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .viol_set  (viol_set),
        .segw_end  (segw_end),
        .rdy       (rdy),
        .lock      (lock),
        .viol      (viol),
        .mode      (mode),
        .emex_req  (emex_req),
        .reg_rdata (reg_rdata)
    );

    fg_op_seq #(
        .PROG_CYC (PROG_CYC),
        .SEG_CYC  (SEG_CYC),
        .MASS_CYC (MASS_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .arr_wr    (arr_wr),
        .lock      (lock),
        .mode      (mode),
        .abort     (emex_req),
        .busy      (busy),
        .op_start  (op_start),
        .op_kind   (kind),
        .op_done   (op_done),
        .segw_mode (segw_mode),
        .segw_end  (segw_end),
        .viol_set  (viol_set)
    );
endmodule

// File: rtl/fg_checker.sv
// Module fg_checker: temporal properties of flash_guard, observed at its ports.
// Assumes reg_sel/reg_wdata encodings from fg_pkg.
module fg_checker
    import fg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       arr_wr,
    input logic       op_start,
    input logic       op_done,
    input logic       busy,
    input logic       violation,
    input logic       locked
);
    logic emex_wr;
    assign emex_wr = reg_wr && reg_sel && reg_wdata[CTL_EMEX];

    p_locked_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked && arr_wr |=> !op_start && violation);

    p_viol_locks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(violation) |-> locked);

    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> busy);

    p_busy_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !emex_wr |=> busy || op_done);

    p_emex_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        emex_wr |=> !busy && !op_done);

    p_emex_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> !reg_rdata[CTL_EMEX]);

    p_busy_wr_viol_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && arr_wr |=> violation && !op_start);
endmodule

bind flash_guard fg_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .arr_wr    (arr_wr),
    .op_start  (op_start),
    .op_done   (op_done),
    .busy      (busy),
    .violation (violation),
    .locked    (locked)
);

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
module flash_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic       reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       arr_wr;
    logic       op_start;
    logic [1:0] op_kind;
    logic       op_done;
    logic       busy;
    logic       violation;
    logic       locked;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    flash_guard u_dut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_sel (reg_sel),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .arr_wr (arr_wr),
        .op_start (op_start), .op_kind (op_kind), .op_done (op_done),
        .busy (busy), .violation (violation), .locked (locked)
    );

    // Vector: {reg_wr, reg_sel, wdata[7:0], arr_wr, exp_busy, exp_viol, exp_lock}
    localparam logic [13:0] VEC [12] = '{
        {1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 unlock
        {1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 program enable
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0},  // R2 start program
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1},  // R10 strobe while busy
        {1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},  // R6 clear flag and lock
        {1'b1, 1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0},  // R9 emergency exit
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},  // R2 no enable left
        {1'b1, 1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 1'b1},  // R5 software lock
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 locked strobe
        {1'b1, 1'b1, 8'h14, 1'b0, 1'b0, 1'b1, 1'b1},  // R6 write 1 keeps flag
        {1'b1, 1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 1'b1},  // R6 write 0 clears flag
        {1'b1, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0}   // R6 write 1 does not set
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One clock of stimulus, returning at the following falling edge.
    task automatic cyc(input logic w, input logic s, input logic [7:0] d, input logic a);
        reg_wr = w; reg_sel = s; reg_wdata = d; arr_wr = a;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00; arr_wr = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [7:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    // Called right after the start strobe; optionally writes the lock mid-run.
    task automatic measure(input string tag, input int exp_n, input logic [1:0] exp_kind,
                           input int lock_at);
        int n = 0;
        chk({tag, " op_start"}, op_start, 1'b1);
        chk({tag, " op_kind"}, op_kind, exp_kind);
        while (busy && n < 200) begin
            n++;
            if (n == lock_at) begin
                reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h10;
            end
            @(negedge clk);
            reg_wr = 1'b0; reg_wdata = 8'h00;
        end
        chk({tag, " busy cycles"}, n, exp_n);
        chk({tag, " op_done"}, op_done, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00; arr_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 locked", locked, 1'b1);
        chk("R1 violation", violation, 1'b0);
        chk("R1 busy", busy, 1'b0);
        rd(1'b1, d); chk("R1 ctrl read", d, 8'h18);
        rd(1'b0, d); chk("R1 mode read", d, 8'h00);

        // Vector walk
        for (int i = 0; i < 12; i++) begin
            cyc(VEC[i][13], VEC[i][12], VEC[i][11:4], VEC[i][3]);
            chk($sformatf("vec%0d busy", i), busy, VEC[i][2]);
            chk($sformatf("vec%0d violation", i), violation, VEC[i][1]);
            chk($sformatf("vec%0d locked", i), locked, VEC[i][0]);
        end

        // R3 durations and kinds, R2 priority
        cyc(1, 0, 8'h01, 0); cyc(0, 0, 8'h00, 1);
        measure("R3 program", 8, 2'd0, 0);
        cyc(1, 0, 8'h02, 0); cyc(0, 0, 8'h00, 1);
        measure("R3 seg erase", 32, 2'd1, 0);
        cyc(1, 0, 8'h06, 0); cyc(0, 0, 8'h00, 1);
        measure("R2 R3 mass priority", 64, 2'd2, 0);

        // R7 lock during segment erase
        cyc(1, 0, 8'h02, 0); cyc(0, 0, 8'h00, 1);
        measure("R7 lock mid erase", 32, 2'd1, 5);
        chk("R7 locked after", locked, 1'b1);
        cyc(0, 0, 8'h00, 1);
        chk("R4 op_start after locked strobe", op_start, 1'b0);
        chk("R4 violation", violation, 1'b1);

        // R5 lock release colliding with a violation
        cyc(1, 1, 8'h00, 1);
        chk("R5 lock kept", locked, 1'b1);
        chk("R5 violation", violation, 1'b1);
        cyc(1, 1, 8'h00, 0);
        chk("R5 released", locked, 1'b0);

        // R9 emergency exit during mass erase
        cyc(1, 0, 8'h04, 0); cyc(0, 0, 8'h00, 1);
        repeat (10) @(negedge clk);
        cyc(1, 1, 8'h20, 0);
        chk("R9 busy dropped", busy, 1'b0);
        chk("R9 no done", op_done, 1'b0);
        @(negedge clk);
        chk("R9 no done later", op_done, 1'b0);
        rd(1'b0, d); chk("R9 mode cleared", d, 8'h00);
        rd(1'b1, d); chk("R9 exit reads 0", d[5], 1'b0);

        // R8 segment-write session ended by lock
        cyc(1, 0, 8'h08, 0); cyc(0, 0, 8'h00, 1);
        measure("R8 word1", 8, 2'd0, 0);
        @(negedge clk);
        rd(1'b1, d); chk("R8 not ready between words", d[3], 1'b0);
        rd(1'b0, d); chk("R8 enable held", d[3], 1'b1);
        cyc(0, 0, 8'h00, 1);
        chk("R8 word2 no violation", violation, 1'b0);
        measure("R8 word2", 8, 2'd0, 2);
        @(negedge clk);
        rd(1'b0, d); chk("R8 enable cleared", d[3], 1'b0);
        rd(1'b1, d); chk("R8 ready again", d[3], 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule